// File: doc/BRIEF.md
# Subaddressed Channel Control Register Target on a Two-Wire Serial Bus

This block is an I2C target that holds one control byte per video channel. A controller on the two-wire bus picks a channel register by sending a one-byte subaddress, then writes one byte into it. It can also read back the byte of the register that is currently selected. The target oversamples SCL and SDA with a faster system clock. It drives SDA only by pulling it low, through an output-enable, and it presents every channel byte as a parallel output for the analog path.

The 7-bit target address has two parts. The upper five bits are a fixed parameter. The lower two bits are taken from two address pins at the moment the address byte has been received. Up to four targets can therefore share one bus, and a board can move a target to another address between transactions.

Each write transaction carries one subaddress byte followed by exactly one data byte. A controller that wants to set all channels sends one transaction per channel. A subaddress sent in a write remains selected for later reads. A read returns only the selected register, and it does not advance to the next one.

Top module: `chan_ctl_i2c_target`

## Requirements
- R1: The target acknowledges an address byte whose bits 7..3 equal 01011, whose bit 2 equals `addr_pin_i[1]` and whose bit 1 equals `addr_pin_i[0]`. Bit 0 selects the direction: 0 is a write and 1 is a read. Any other address byte is not acknowledged, and every later byte up to the next START is not acknowledged either.
- R2: The address pins are not latched. Changing them between transactions changes the address that the target answers to in the next transaction.
- R3: In a write, subaddresses 0x01, 0x02 and 0x03 select channels 1, 2 and 3 (`ch_val_o[7:0]`, `[15:8]`, `[23:16]`), and the target acknowledges them. Any other subaddress is not acknowledged. Such a subaddress leaves the selection unchanged, and the target ignores the bytes that follow it.
- R4: The data byte is acknowledged and written to the selected channel, and the new value appears only after its acknowledge clock. A second data byte in the same transaction is not acknowledged and has no effect.
- R5: A read shifts out the selected register MSB first. SDA changes only while SCL is low.
- R6: A subaddress written before a repeated START stays selected for the read that follows it.
- R7: If the controller acknowledges a read byte, the same register byte is sent again. If it does not acknowledge, the target releases SDA and ignores all clocks until the next START or STOP.
- R8: A START or STOP in the middle of a byte aborts it. A partially received data byte is never written, and after a STOP the target does not drive SDA.
- R9: An acknowledge drive is released at the falling SCL edge that ends the ninth clock, so one SCL cycle always frees SDA.
- R10: Reset releases SDA and selects channel 1. Reset does not clear the channel registers, and their contents are undefined until they are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| addr_pin_i | input | 2 | Live low address bits {A1, A0} |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| ch_val_o | output | 8*NUM_CH | Channel registers, channel 1 in the low byte |

## Verification
The bench goes after the bytes that must be refused. These are a foreign address, a subaddress of 0x00 or 0x04, and a second data byte. A design that accepts any of them would acknowledge it or corrupt a channel, and the reference model, which compares every channel on each SCL-high phase, would see it. Pin changes between transactions catch a design that latches the address. Aborts by STOP and by repeated START in the middle of a data byte catch a design that writes partial bytes. The bench also checks that after a read NACK the target ignores extra clocks, and that channel contents survive a reset.

// File: rtl/i2cs_chan_pkg.sv
package i2cs_chan_pkg;
   localparam int BYTE_W = 8;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ADDR = 3'd1,
      ST_SUB  = 3'd2,
      ST_DATA = 3'd3,
      ST_READ = 3'd4,
      ST_HOLD = 3'd5
   } tgt_state_e;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] sync_o
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("i2cs_line_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '1;
            else if (s == 0) chain[s] <= raw_i;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic ev_start,
   output logic ev_stop
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign ev_start = scl_s & scl_p & sda_p & ~sda_s;
   assign ev_stop  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cs_chan_bank.sv
module i2cs_chan_bank #(
   parameter int NUM_CH = 3,
   parameter int IDX_W  = 2
) (
   input  logic                           clk,
   input  logic                           wr_en,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [i2cs_chan_pkg::BYTE_W-1:0] wr_data,
   input  logic [IDX_W-1:0]               rd_idx,
   output logic [i2cs_chan_pkg::BYTE_W-1:0] rd_data,
   output logic [NUM_CH*i2cs_chan_pkg::BYTE_W-1:0] ch_flat
);
   import i2cs_chan_pkg::*;

   logic [BYTE_W-1:0] regs [NUM_CH];

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(c))) regs[c] <= wr_data;
         end
         assign ch_flat[c*BYTE_W +: BYTE_W] = regs[c];
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (rd_idx == IDX_W'(c)) rd_data = regs[c];
      end
   end
endmodule

// File: rtl/chan_ctl_i2c_target.sv
module chan_ctl_i2c_target #(
   parameter logic [4:0] ADDR_PREFIX = 5'b01011,
   parameter int         NUM_CH      = 3,
   parameter int         SUB_BASE    = 1,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_i,
   input  logic                   sda_i,
   input  logic [1:0]             addr_pin_i,
   output logic                   sda_oe_o,
   output logic [8*NUM_CH-1:0]    ch_val_o
);
   import i2cs_chan_pkg::*;

   localparam int SUB_LAST = SUB_BASE + NUM_CH - 1;
   localparam int IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   generate
      if (NUM_CH < 1 || SUB_BASE < 0 || SUB_LAST > 255) begin : g_bad_map
         $error("channel subaddress window must fit in one byte");
      end
   endgenerate

   logic [1:0] line_s;
   logic       scl_q, sda_q;
   logic       scl_rise, scl_fall, ev_start, ev_stop;

   i2cs_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .raw_i({scl_i, sda_i}), .sync_o(line_s));
   assign scl_q = line_s[1];
   assign sda_q = line_s[0];

   i2cs_bus_events ev_i (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_q), .sda_s(sda_q),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .ev_start(ev_start), .ev_stop(ev_stop));

   tgt_state_e        state;
   logic [3:0]        bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] tx_byte;
   logic [BYTE_W-1:0] sel_sub;
   logic              ack_ph;
   logic              oe_q;
   logic              accept;
   logic              wr_en;
   logic [IDX_W-1:0]  sel_idx;
   logic [BYTE_W-1:0] rd_val;

   assign sel_idx = IDX_W'(sel_sub - BYTE_W'(SUB_BASE));

   always_comb begin
      unique case (state)
         ST_ADDR: accept = (shreg[7:1] == {ADDR_PREFIX, addr_pin_i});
         ST_SUB:  accept = (shreg >= BYTE_W'(SUB_BASE)) && (shreg <= BYTE_W'(SUB_LAST));
         ST_DATA: accept = 1'b1;
         default: accept = 1'b0;
      endcase
   end

   assign wr_en = (state == ST_DATA) && ack_ph && oe_q && scl_fall && !ev_start && !ev_stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bit_cnt <= '0;
         shreg   <= '0;
         tx_byte <= '0;
         sel_sub <= BYTE_W'(SUB_BASE);
         ack_ph  <= 1'b0;
         oe_q    <= 1'b0;
      end else if (ev_start) begin
         state   <= ST_ADDR;
         bit_cnt <= '0;
         ack_ph  <= 1'b0;
         oe_q    <= 1'b0;
      end else if (ev_stop) begin
         state   <= ST_IDLE;
         bit_cnt <= '0;
         ack_ph  <= 1'b0;
         oe_q    <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR, ST_SUB, ST_DATA: begin
               if (scl_rise && !ack_ph && bit_cnt < 4'd8) begin
                  shreg   <= {shreg[BYTE_W-2:0], sda_q};
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (scl_fall && !ack_ph && bit_cnt == 4'd8) begin
                  ack_ph <= 1'b1;
                  oe_q   <= accept;
               end else if (scl_fall && ack_ph) begin
                  ack_ph  <= 1'b0;
                  bit_cnt <= '0;
                  oe_q    <= 1'b0;
                  if (!oe_q) begin
                     state <= ST_HOLD;
                  end else if (state == ST_ADDR) begin
                     if (shreg[0]) begin
                        state   <= ST_READ;
                        tx_byte <= rd_val;
                        oe_q    <= ~rd_val[7];
                     end else begin
                        state <= ST_SUB;
                     end
                  end else if (state == ST_SUB) begin
                     sel_sub <= shreg;
                     state   <= ST_DATA;
                  end else begin
                     state <= ST_HOLD;
                  end
               end
            end
            ST_READ: begin
               if (!ack_ph) begin
                  if (scl_rise && bit_cnt < 4'd8) begin
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall && bit_cnt == 4'd8) begin
                     oe_q   <= 1'b0;
                     ack_ph <= 1'b1;
                  end else if (scl_fall && bit_cnt != 4'd0) begin
                     oe_q <= ~tx_byte[3'd7 - bit_cnt[2:0]];
                  end
               end else begin
                  if (scl_rise && sda_q) begin
                     state  <= ST_HOLD;
                     ack_ph <= 1'b0;
                  end else if (scl_fall) begin
                     ack_ph  <= 1'b0;
                     bit_cnt <= '0;
                     tx_byte <= rd_val;
                     oe_q    <= ~rd_val[7];
                  end
               end
            end
            default: begin
               oe_q    <= 1'b0;
               ack_ph  <= 1'b0;
               bit_cnt <= '0;
            end
         endcase
      end
   end

   i2cs_chan_bank #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) bank_i (
      .clk(clk), .wr_en(wr_en), .wr_idx(sel_idx), .wr_data(shreg),
      .rd_idx(sel_idx), .rd_data(rd_val), .ch_flat(ch_val_o));

   assign sda_oe_o = oe_q;
endmodule

// File: rtl/chan_ctl_i2c_chk.sv
module chan_ctl_i2c_chk #(
   parameter int NUM_CH = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                scl_s,
   input logic                scl_fall,
   input logic                ev_stop,
   input logic                ack_ph,
   input logic [2:0]          state,
   input logic                sda_oe,
   input logic [8*NUM_CH-1:0] ch_val
);
   import i2cs_chan_pkg::*;

   // R5: the target moves SDA only while SCL is low
   p_oe_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(sda_oe) |-> !$past(scl_s));

   // R9: an acknowledge drive ends with the falling edge of the ninth clock
   p_ack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_ph && sda_oe && scl_fall &&
       (state == 3'(ST_SUB) || state == 3'(ST_DATA))) |=> !sda_oe);

   // R4: a channel changes only right after an acknowledged data byte
   p_write_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(ch_val) |-> ($past(sda_oe) && $past(state) == 3'(ST_DATA)));

   // R8: after a STOP the target is idle and not driving
   p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |=> (!sda_oe && state == 3'(ST_IDLE)));

   // R7: a held target never drives SDA
   p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 3'(ST_HOLD) && $past(state) == 3'(ST_HOLD)) |-> !sda_oe);
endmodule

bind chan_ctl_i2c_target chan_ctl_i2c_chk #(.NUM_CH(NUM_CH)) chk_i (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_q), .scl_fall(scl_fall),
   .ev_stop(ev_stop), .ack_ph(ack_ph), .state(state),
   .sda_oe(sda_oe_o), .ch_val(ch_val_o));

// File: tb/chan_ctl_i2c_target_tb.sv
module chan_ctl_i2c_target_tb_top;
   localparam int Q = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_drv = 1'b1;
   logic        sda_drv = 1'b1;
   logic [1:0]  pins = 2'b00;
   logic        sda_oe;
   logic [23:0] ch_val;
   logic        sda_bus;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   logic [7:0] exp_v [3];
   bit         known [3];

   always #4 clk = ~clk;

   assign sda_bus = sda_drv & ~sda_oe;

   chan_ctl_i2c_target dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_bus),
      .addr_pin_i(pins), .sda_oe_o(sda_oe), .ch_val_o(ch_val));

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   // reference model: every channel that has been written must hold its value
   always @(negedge clk) begin
      if (rst_n && scl_drv && !done) begin
         for (int c = 0; c < 3; c++) begin
            if (known[c]) check(ch_val[c*8 +: 8] == exp_v[c], "R4 model", ch_val[c*8 +: 8], exp_v[c]);
         end
      end
   end

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_drv = 1'b1; wq();
      scl_drv = 1'b1; wq();
      sda_drv = 1'b0; wq();
      scl_drv = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_drv = 1'b0; wq();
      scl_drv = 1'b1; wq();
      sda_drv = 1'b1; wq();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_drv = b[i]; wq();
         scl_drv = 1'b1; wq();
         scl_drv = 1'b0; wq();
      end
   endtask

   task automatic xfer(input logic [7:0] b, input bit exp_ack, input bit chk_rel, input string req);
      bit got;
      send_bits(b, 8);
      sda_drv = 1'b1; wq();
      scl_drv = 1'b1; wq();
      got = !sda_bus;
      check(got == exp_ack, req, got, exp_ack);
      scl_drv = 1'b0; wq();
      if (chk_rel && got) check(sda_oe == 1'b0, "R9 release", sda_oe, 0);
   endtask

   task automatic recv(input bit m_ack, input logic [7:0] expv, input string req);
      logic [7:0] r;
      sda_drv = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq();
         scl_drv = 1'b1; wq();
         r[i] = sda_bus;
         scl_drv = 1'b0;
      end
      sda_drv = !m_ack; wq();
      scl_drv = 1'b1; wq();
      scl_drv = 1'b0; wq();
      sda_drv = 1'b1;
      check(r == expv, req, r, expv);
   endtask

   function automatic logic [7:0] adr(input logic [1:0] p, input bit rd);
      return {5'b01011, p, rd};
   endfunction

   task automatic wr_reg(input logic [1:0] p, input logic [7:0] sub, input logic [7:0] d);
      bus_start();
      xfer(adr(p, 1'b0), 1'b1, 1'b1, "R1 addr");
      xfer(sub, 1'b1, 1'b1, "R3 sub");
      xfer(d, 1'b1, 1'b1, "R4 data");
      exp_v[sub-1] = d;
      known[sub-1] = 1'b1;
      bus_stop();
   endtask

   task automatic rd_reg(input logic [1:0] p, input logic [7:0] sub, input string req);
      bus_start();
      xfer(adr(p, 1'b0), 1'b1, 1'b1, "R1 addr");
      xfer(sub, 1'b1, 1'b1, "R3 sub");
      bus_start();
      xfer(adr(p, 1'b1), 1'b1, 1'b0, "R6 raddr");
      recv(1'b0, exp_v[sub-1], req);
      bus_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 3; c++) known[c] = 1'b0;
      repeat (5) @(negedge clk);
      check(sda_oe == 1'b0, "R10 reset oe", sda_oe, 0);
      rst_n = 1'b1;
      wq();

      // basic writes and reads
      wr_reg(2'b00, 8'h01, 8'hA5);
      wr_reg(2'b00, 8'h02, 8'h3C);
      wr_reg(2'b00, 8'h03, 8'h96);
      rd_reg(2'b00, 8'h02, "R5 read ch2");
      rd_reg(2'b00, 8'h01, "R6 read ch1");

      // wrong address, later bytes ignored (R1)
      pins = 2'b10;
      bus_start();
      xfer(adr(2'b00, 1'b0), 1'b0, 1'b0, "R1 foreign addr");
      xfer(8'h01, 1'b0, 1'b0, "R1 ignore after nack");
      xfer(8'h00, 1'b0, 1'b0, "R1 ignore data");
      bus_stop();

      // live pins (R2)
      wr_reg(2'b10, 8'h01, 8'h11);
      pins = 2'b01;
      wr_reg(2'b01, 8'h01, 8'h22);
      bus_start();
      xfer(adr(2'b10, 1'b0), 1'b0, 1'b0, "R2 old pins refused");
      bus_stop();

      // bad subaddresses (R3)
      bus_start();
      xfer(adr(2'b01, 1'b0), 1'b1, 1'b1, "R1 addr");
      xfer(8'h00, 1'b0, 1'b0, "R3 sub 0x00");
      xfer(8'hEE, 1'b0, 1'b0, "R3 ignored data");
      bus_stop();
      bus_start();
      xfer(adr(2'b01, 1'b0), 1'b1, 1'b1, "R1 addr");
      xfer(8'h04, 1'b0, 1'b0, "R3 sub 0x04");
      bus_stop();
      bus_start();
      xfer(adr(2'b01, 1'b1), 1'b1, 1'b0, "R3 raddr");
      recv(1'b0, 8'h22, "R3 selection kept");
      bus_stop();

      // second data byte refused (R4)
      bus_start();
      xfer(adr(2'b01, 1'b0), 1'b1, 1'b1, "R1 addr");
      xfer(8'h03, 1'b1, 1'b1, "R3 sub");
      xfer(8'h77, 1'b1, 1'b1, "R4 data");
      exp_v[2] = 8'h77;
      xfer(8'h88, 1'b0, 1'b0, "R4 second data");
      bus_stop();
      rd_reg(2'b01, 8'h03, "R4 ch3 keeps first byte");

      // aborts (R8)
      bus_start();
      xfer(adr(2'b01, 1'b0), 1'b1, 1'b1, "R1 addr");
      xfer(8'h02, 1'b1, 1'b1, "R3 sub");
      send_bits(8'h00, 4);
      bus_stop();
      check(sda_oe == 1'b0, "R8 stop releases", sda_oe, 0);
      bus_start();
      xfer(adr(2'b01, 1'b0), 1'b1, 1'b1, "R1 addr");
      xfer(8'h02, 1'b1, 1'b1, "R3 sub");
      send_bits(8'h55, 5);
      bus_start();
      xfer(adr(2'b01, 1'b1), 1'b1, 1'b0, "R6 raddr");
      recv(1'b0, 8'h3C, "R8 ch2 after abort");
      bus_stop();

      // controller ACK repeats, NACK releases (R7)
      bus_start();
      xfer(adr(2'b01, 1'b1), 1'b1, 1'b0, "R7 raddr");
      recv(1'b1, 8'h3C, "R7 first byte");
      recv(1'b0, 8'h3C, "R7 repeated byte");
      check(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
      xfer(8'h00, 1'b0, 1'b0, "R7 clocks ignored");
      bus_stop();

      // reset keeps channel contents, selects channel 1 (R10)
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      check(sda_oe == 1'b0, "R10 reset oe", sda_oe, 0);
      rst_n = 1'b1;
      wq();
      bus_start();
      xfer(adr(2'b01, 1'b1), 1'b1, 1'b0, "R10 raddr");
      recv(1'b0, 8'h22, "R10 ch1 kept and selected");
      bus_stop();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule